// File: doc/BRIEF.md
# Radio GPIO Bank with Automatic Transmit/Receive Outputs

This block is a 16-bit bus slave on a simple single-cycle-acknowledge wishbone port. It drives two 16-pin I/O banks, one serving the receive side of a radio front end and one the transmit side. For each bank, software programs four words: an output value, a direction mask, a source-select mask and a debug mask. Each bit of a bank's output comes from one of four places. These are the software value, an entry of an automatic transmit/receive table, and two debug buses from the surrounding fabric.

The table holds one output word per side for each of four radio conditions: idle, transmitting only, receiving only, and both at once. Two run-status inputs pick the condition. The chosen word reaches the pins one clock later, so front-end switches and amplifier enables follow the radio without software involvement.

Software reads the live pin levels back through the value register. Pad cells sit outside the block: it supplies a per-pin output value and an output enable. The bus has no back-pressure. Every strobed cycle is acknowledged exactly one clock later, and the master must hold its request until the acknowledge arrives.

Top module: `gpio_atr_bank`

## Requirements
- R1: Addresses are byte addresses and every access is a full 16-bit word. Address bit 0 plays no part in decoding, so an odd address reaches the same register as the even address below it.
- R2: After reset, every register and every table entry reads zero, every output enable is low and every output value is low.
- R3: An access (strobe and cycle both high) is acknowledged on the first rising edge after it starts. The acknowledge is a single-cycle pulse, and a write takes effect at that same edge.
- R4: Bank registers sit at byte addresses below 16, with the receive bank at the even word and the transmit bank at the next word. Output value is at 0/2, direction at 4/6, source select at 8/10 and debug enable at 12/14. Direction, select and debug read back as written.
- R5: A read of the output value address (0 or 2) returns the current pin inputs of that bank, not the written value.
- R6: For a pin whose debug bit is 0, select bit 0 drives the software value and select bit 1 drives the table word for the current radio condition.
- R7: For a pin whose debug bit is 1, select bit 0 drives debug bus 0 of that bank and select bit 1 drives debug bus 1.
- R8: The table occupies byte addresses 16 to 30. Receive-side entries are at 16/20/24/28 and transmit-side entries at 18/22/26/30, for idle, transmit only, receive only and full duplex in that order. Entries read back as written.
- R9: The radio condition is {tx_run, rx_run}: 00 idle, 10 transmit only, 01 receive only, 11 full duplex. A change of these inputs changes the table word on the pins at the next rising edge, not before.
- R10: Each pin's output enable equals its direction bit (1 = output). A pin whose direction bit is 0 drives an output value of 0, whatever its select and debug bits say.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wb_adr_i | input | 5 | Byte address |
| wb_dat_i | input | 16 | Write data |
| wb_we_i | input | 1 | Write enable |
| wb_stb_i | input | 1 | Strobe |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_dat_o | output | 16 | Read data, valid with acknowledge |
| wb_ack_o | output | 1 | Acknowledge |
| tx_run | input | 1 | Transmit chain active |
| rx_run | input | 1 | Receive chain active |
| dbg0_rx | input | 16 | Debug bus 0 for the receive bank |
| dbg1_rx | input | 16 | Debug bus 1 for the receive bank |
| dbg0_tx | input | 16 | Debug bus 0 for the transmit bank |
| dbg1_tx | input | 16 | Debug bus 1 for the transmit bank |
| pin_rx_i | input | 16 | Receive bank pin levels |
| pin_tx_i | input | 16 | Transmit bank pin levels |
| pin_rx_o | output | 16 | Receive bank output values |
| pin_rx_oe | output | 16 | Receive bank output enables |
| pin_tx_o | output | 16 | Transmit bank output values |
| pin_tx_oe | output | 16 | Transmit bank output enables |

## Verification
The hardest case to reach is a pin mask that mixes all four sources while the radio condition changes in the same interval. Only a few bit combinations let a wrong table row or a swapped debug bus show up at a pin. The stimulus writes random direction, select and debug masks, fills every table entry with a distinct random word, and then walks the run inputs through random conditions while the debug buses and pin levels change. Each output is checked one edge after the change. A directed step also looks at the pins just before that edge, to confirm that the old table row is still being driven.

// File: rtl/gpio_atr_pkg.sv
package gpio_atr_pkg;
  localparam int NSIDE  = 2;
  localparam int NSTATE = 4;

  typedef enum logic [1:0] {
    KIND_VAL = 2'd0,
    KIND_DIR = 2'd1,
    KIND_SRC = 2'd2,
    KIND_DBG = 2'd3
  } reg_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_TX_ONLY = 2'd1,
    ST_RX_ONLY = 2'd2,
    ST_DUPLEX  = 2'd3
  } radio_state_e;

  function automatic radio_state_e run_to_state(input logic tx, input logic rx);
    case ({tx, rx})
      2'b00:   return ST_IDLE;
      2'b10:   return ST_TX_ONLY;
      2'b01:   return ST_RX_ONLY;
      default: return ST_DUPLEX;
    endcase
  endfunction
endpackage

// File: rtl/gpio_wb_regs.sv
module gpio_wb_regs
  import gpio_atr_pkg::*;
#(
  parameter int DW = 16,
  parameter int IW = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [IW-1:0]              wadr,
  input  logic [DW-1:0]              wdat,
  input  logic                       we,
  input  logic                       stb,
  input  logic                       cyc,
  output logic [DW-1:0]              rdat,
  output logic                       ack,
  input  logic [NSIDE-1:0][DW-1:0]   pin_in,
  output logic [NSIDE-1:0][DW-1:0]   val_q,
  output logic [NSIDE-1:0][DW-1:0]   dir_q,
  output logic [NSIDE-1:0][DW-1:0]   src_q,
  output logic [NSIDE-1:0][DW-1:0]   dbg_q,
  output logic                       tbl_we,
  output logic [IW-2:0]              tbl_idx,
  input  logic [DW-1:0]              tbl_rdat
);
  localparam int SIDEW = $clog2(NSIDE);

  logic             access;
  logic             in_table;
  logic [SIDEW-1:0] side;
  reg_kind_e        kind;
  logic [DW-1:0]    rd_mux;

  assign access   = stb && cyc && !ack;
  assign in_table = wadr[IW-1];
  assign side     = wadr[SIDEW-1:0];
  assign kind     = reg_kind_e'(wadr[IW-2:1]);
  assign tbl_we   = access && we && in_table;
  assign tbl_idx  = wadr[IW-2:0];

  always_comb begin
    if (in_table) begin
      rd_mux = tbl_rdat;
    end else begin
      case (kind)
        KIND_VAL: rd_mux = pin_in[side];
        KIND_DIR: rd_mux = dir_q[side];
        KIND_SRC: rd_mux = src_q[side];
        default:  rd_mux = dbg_q[side];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack   <= 1'b0;
      rdat  <= '0;
      val_q <= '0;
      dir_q <= '0;
      src_q <= '0;
      dbg_q <= '0;
    end else begin
      ack <= access;
      if (access) begin
        rdat <= rd_mux;
        if (we && !in_table) begin
          case (kind)
            KIND_VAL: val_q[side] <= wdat;
            KIND_DIR: dir_q[side] <= wdat;
            KIND_SRC: src_q[side] <= wdat;
            default:  dbg_q[side] <= wdat;
          endcase
        end
      end
    end
  end

  p_ack_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  p_ack_after_req_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> $past(stb && cyc));

  p_dir_write_r4: assert property (@(posedge clk) disable iff (rst)
    (stb && cyc && !ack && we && wadr == 4'd2) |=> dir_q[0] == $past(wdat));
endmodule

// File: rtl/gpio_atr_table.sv
module gpio_atr_table
  import gpio_atr_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tx_run,
  input  logic                     rx_run,
  input  logic                     wr_en,
  input  logic [IDXW-1:0]          idx,
  input  logic [DW-1:0]            wdat,
  output logic [DW-1:0]            rdat,
  output logic [NSIDE-1:0][DW-1:0] word
);
  localparam int NENT = NSIDE * NSTATE;
  localparam int IDXW = $clog2(NENT);
  localparam int SIDEW = $clog2(NSIDE);

  logic [DW-1:0] tbl [NENT];
  radio_state_e  state_q;
  logic          primed;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      primed  <= 1'b0;
      for (int i = 0; i < NENT; i++) tbl[i] <= '0;
    end else begin
      state_q <= run_to_state(tx_run, rx_run);
      primed  <= 1'b1;
      if (wr_en) tbl[idx] <= wdat;
    end
  end

  assign rdat = tbl[idx];

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    localparam logic [SIDEW-1:0] SIDE_SEL = SIDEW'(s);
    assign word[s] = tbl[{state_q, SIDE_SEL}];
  end

  p_word_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (primed && !wr_en && $stable(tx_run) && $stable(rx_run)) |=> $stable(word));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] val,
  input  logic [DW-1:0] dir,
  input  logic [DW-1:0] src,
  input  logic [DW-1:0] dbg,
  input  logic [DW-1:0] atr,
  input  logic [DW-1:0] bus0,
  input  logic [DW-1:0] bus1,
  output logic [DW-1:0] pin_o,
  output logic [DW-1:0] pin_oe
);
  for (genvar b = 0; b < DW; b++) begin : g_bit
    logic normal_pick;
    logic debug_pick;
    logic pick;
    assign normal_pick = src[b] ? atr[b]  : val[b];
    assign debug_pick  = src[b] ? bus1[b] : bus0[b];
    assign pick        = dbg[b] ? debug_pick : normal_pick;
    assign pin_o[b]    = dir[b] & pick;
    assign pin_oe[b]   = dir[b];
  end

  p_sw_path_r6: assert property (@(posedge clk) disable iff (rst)
    (dir == '1 && dbg == '0 && src == '0) |-> pin_o == val);

  p_dbg_path_r7: assert property (@(posedge clk) disable iff (rst)
    (dir == '1 && dbg == '1 && src == '1) |-> pin_o == bus1);
endmodule

// File: rtl/gpio_atr_bank.sv
module gpio_atr_bank
  import gpio_atr_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [4:0]    wb_adr_i,
  input  logic [DW-1:0] wb_dat_i,
  input  logic          wb_we_i,
  input  logic          wb_stb_i,
  input  logic          wb_cyc_i,
  output logic [DW-1:0] wb_dat_o,
  output logic          wb_ack_o,
  input  logic          tx_run,
  input  logic          rx_run,
  input  logic [DW-1:0] dbg0_rx,
  input  logic [DW-1:0] dbg1_rx,
  input  logic [DW-1:0] dbg0_tx,
  input  logic [DW-1:0] dbg1_tx,
  input  logic [DW-1:0] pin_rx_i,
  input  logic [DW-1:0] pin_tx_i,
  output logic [DW-1:0] pin_rx_o,
  output logic [DW-1:0] pin_rx_oe,
  output logic [DW-1:0] pin_tx_o,
  output logic [DW-1:0] pin_tx_oe
);
  localparam int AW   = 5;
  localparam int IW   = AW - 1;
  localparam int IDXW = $clog2(NSIDE * NSTATE);

  logic [NSIDE-1:0][DW-1:0] pin_in, val_q, dir_q, src_q, dbg_q, atr_word;
  logic [NSIDE-1:0][DW-1:0] bus0, bus1, pin_o, pin_oe;
  logic                     tbl_we;
  logic [IDXW-1:0]          tbl_idx;
  logic [DW-1:0]            tbl_rdat;
  logic                     unused_adr_lsb;

  assign unused_adr_lsb = wb_adr_i[0];
  assign pin_in = {pin_tx_i, pin_rx_i};
  assign bus0   = {dbg0_tx, dbg0_rx};
  assign bus1   = {dbg1_tx, dbg1_rx};

  gpio_wb_regs #(.DW(DW), .IW(IW)) u_regs (
    .clk(clk), .rst(rst),
    .wadr(wb_adr_i[AW-1:1]), .wdat(wb_dat_i), .we(wb_we_i),
    .stb(wb_stb_i), .cyc(wb_cyc_i), .rdat(wb_dat_o), .ack(wb_ack_o),
    .pin_in(pin_in), .val_q(val_q), .dir_q(dir_q), .src_q(src_q), .dbg_q(dbg_q),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_rdat(tbl_rdat)
  );

  gpio_atr_table #(.DW(DW)) u_table (
    .clk(clk), .rst(rst), .tx_run(tx_run), .rx_run(rx_run),
    .wr_en(tbl_we), .idx(tbl_idx), .wdat(wb_dat_i),
    .rdat(tbl_rdat), .word(atr_word)
  );

  for (genvar s = 0; s < NSIDE; s++) begin : g_bank
    gpio_pin_mux #(.DW(DW)) u_mux (
      .clk(clk), .rst(rst),
      .val(val_q[s]), .dir(dir_q[s]), .src(src_q[s]), .dbg(dbg_q[s]),
      .atr(atr_word[s]), .bus0(bus0[s]), .bus1(bus1[s]),
      .pin_o(pin_o[s]), .pin_oe(pin_oe[s])
    );
  end

  assign pin_rx_o  = pin_o[0];
  assign pin_rx_oe = pin_oe[0];
  assign pin_tx_o  = pin_o[1];
  assign pin_tx_oe = pin_oe[1];
endmodule

// File: tb/gpio_atr_bank_bench.sv
`timescale 1ns/1ps
module gpio_atr_bank_bench;
  localparam real TCLK = 4.0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  wb_adr_i = '0;
  logic [15:0] wb_dat_i = '0;
  logic        wb_we_i = 1'b0, wb_stb_i = 1'b0, wb_cyc_i = 1'b0;
  logic [15:0] wb_dat_o;
  logic        wb_ack_o;
  logic        tx_run = 1'b0, rx_run = 1'b0;
  logic [15:0] dbg0_rx = '0, dbg1_rx = '0, dbg0_tx = '0, dbg1_tx = '0;
  logic [15:0] pin_rx_i = '0, pin_tx_i = '0;
  logic [15:0] pin_rx_o, pin_rx_oe, pin_tx_o, pin_tx_oe;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [15:0] m_val [2];
  logic [15:0] m_dir [2];
  logic [15:0] m_src [2];
  logic [15:0] m_dbg [2];
  logic [15:0] m_tbl [8];

  always #(TCLK/2) clk = ~clk;

  gpio_atr_bank u_gpio_atr_bank (
    .clk(clk), .rst(rst), .wb_adr_i(wb_adr_i), .wb_dat_i(wb_dat_i),
    .wb_we_i(wb_we_i), .wb_stb_i(wb_stb_i), .wb_cyc_i(wb_cyc_i),
    .wb_dat_o(wb_dat_o), .wb_ack_o(wb_ack_o), .tx_run(tx_run), .rx_run(rx_run),
    .dbg0_rx(dbg0_rx), .dbg1_rx(dbg1_rx), .dbg0_tx(dbg0_tx), .dbg1_tx(dbg1_tx),
    .pin_rx_i(pin_rx_i), .pin_tx_i(pin_tx_i), .pin_rx_o(pin_rx_o),
    .pin_rx_oe(pin_rx_oe), .pin_tx_o(pin_tx_o), .pin_tx_oe(pin_tx_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int state_row(input logic tx, input logic rx);
    if (tx && rx) return 3;
    if (tx) return 1;
    if (rx) return 2;
    return 0;
  endfunction

  function automatic logic [15:0] exp_pin(input int s, input int row);
    logic [15:0] atr, d0, d1, nrm, dpk;
    atr = m_tbl[row*2 + s];
    d0  = (s == 0) ? dbg0_rx : dbg0_tx;
    d1  = (s == 0) ? dbg1_rx : dbg1_tx;
    nrm = (m_src[s] & atr) | (~m_src[s] & m_val[s]);
    dpk = (m_src[s] & d1) | (~m_src[s] & d0);
    return ((m_dbg[s] & dpk) | (~m_dbg[s] & nrm)) & m_dir[s];
  endfunction

  task automatic xfer(input logic we, input logic [4:0] a, input logic [15:0] d,
                      output logic [15:0] q);
    @(negedge clk);
    wb_adr_i = a; wb_dat_i = d; wb_we_i = we; wb_stb_i = 1'b1; wb_cyc_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R3 ack one cycle after strobe", {31'd0, wb_ack_o}, 32'd1);
    q = wb_dat_o;
    wb_stb_i = 1'b0; wb_cyc_i = 1'b0; wb_we_i = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    logic [15:0] q;
    int w;
    xfer(1'b1, a, d, q);
    w = int'(a[3:1]);
    if (a[4]) m_tbl[w] = d;
    else case (w / 2)
      0: m_val[w % 2] = d;
      1: m_dir[w % 2] = d;
      2: m_src[w % 2] = d;
      default: m_dbg[w % 2] = d;
    endcase
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] q);
    xfer(1'b0, a, 16'h0000, q);
  endtask

  task automatic check_pins(input string req, input int row);
    chk(req, {16'd0, pin_rx_o}, {16'd0, exp_pin(0, row)});
    chk(req, {16'd0, pin_tx_o}, {16'd0, exp_pin(1, row)});
    chk("R10 oe follows direction", {pin_tx_oe, pin_rx_oe}, {m_dir[1], m_dir[0]});
  endtask

  initial begin
    #(TCLK * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] q;
    logic [15:0] r;
    int row;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 2; i++) begin
      m_val[i] = '0; m_dir[i] = '0; m_src[i] = '0; m_dbg[i] = '0;
    end
    for (int i = 0; i < 8; i++) m_tbl[i] = '0;

    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R2 reset state
    chk("R2 reset oe", {pin_tx_oe, pin_rx_oe}, 32'd0);
    chk("R2 reset out", {pin_tx_o, pin_rx_o}, 32'd0);
    for (int a = 4; a < 32; a += 2) begin
      rd(5'(a), q);
      chk("R2 reset register zero", {16'd0, q}, 32'd0);
    end

    // R3 directed: no ack before the edge, single pulse after
    @(negedge clk);
    wb_adr_i = 5'd4; wb_we_i = 1'b0; wb_stb_i = 1'b1; wb_cyc_i = 1'b1;
    #0.5;
    chk("R3 no ack before edge", {31'd0, wb_ack_o}, 32'd0);
    @(negedge clk);
    chk("R3 ack after edge", {31'd0, wb_ack_o}, 32'd1);
    @(negedge clk);
    chk("R3 ack is a pulse", {31'd0, wb_ack_o}, 32'd0);
    wb_stb_i = 1'b0; wb_cyc_i = 1'b0;

    // R4 register map readback
    for (int a = 4; a < 16; a += 2) begin
      r = 16'($urandom);
      wr(5'(a), r);
    end
    for (int a = 4; a < 16; a += 2) begin
      rd(5'(a), q);
      chk("R4 register readback", {16'd0, q}, {16'd0, (a < 8) ? m_dir[(a/2)%2] :
                                              (a < 12) ? m_src[(a/2)%2] : m_dbg[(a/2)%2]});
    end

    // R1 odd address reaches the even register
    wr(5'd7, 16'hC3A5);
    rd(5'd6, q);
    chk("R1 odd write lands on even word", {16'd0, q}, 32'h0000C3A5);
    rd(5'd13, q);
    chk("R1 odd read", {16'd0, q}, {16'd0, m_dbg[0]});

    // R5 value read returns live pins
    wr(5'd0, 16'hAAAA);
    wr(5'd2, 16'h5555);
    pin_rx_i = 16'h1234; pin_tx_i = 16'hFEDC;
    rd(5'd0, q);
    chk("R5 rx value reads pins", {16'd0, q}, 32'h00001234);
    rd(5'd3, q);
    chk("R5 tx value reads pins", {16'd0, q}, 32'h0000FEDC);

    // R8 table fill and readback
    for (int e = 0; e < 8; e++) begin
      r = 16'($urandom);
      wr(5'(16 + 2*e), r);
    end
    for (int e = 0; e < 8; e++) begin
      rd(5'(16 + 2*e), q);
      chk("R8 table readback", {16'd0, q}, {16'd0, m_tbl[e]});
    end

    // R6 directed software path, R10 masked pins
    wr(5'd4, 16'h0FF0); wr(5'd6, 16'hFFFF);
    wr(5'd8, 16'h0000); wr(5'd10, 16'h0000);
    wr(5'd12, 16'h0000); wr(5'd14, 16'h0000);
    @(negedge clk);
    chk("R6 software value on outputs", {16'd0, pin_tx_o}, {16'd0, m_val[1]});
    chk("R10 input pins drive zero", {16'd0, pin_rx_o}, {16'd0, m_val[0] & 16'h0FF0});

    // R7 directed debug buses
    wr(5'd12, 16'hFFFF); wr(5'd8, 16'h00FF);
    dbg0_rx = 16'h1357; dbg1_rx = 16'h9BDF;
    @(negedge clk);
    chk("R7 debug bus pick", {16'd0, pin_rx_o},
        {16'd0, ((16'h9BDF & 16'h00FF) | (16'h1357 & 16'hFF00)) & 16'h0FF0});

    // R9 directed latency: table row changes only at the next edge
    wr(5'd4, 16'hFFFF); wr(5'd12, 16'h0000); wr(5'd8, 16'hFFFF);
    @(negedge clk);
    chk("R9 idle row", {16'd0, pin_rx_o}, {16'd0, m_tbl[0]});
    tx_run = 1'b1; rx_run = 1'b0;
    #0.5;
    chk("R9 old row before edge", {16'd0, pin_rx_o}, {16'd0, m_tbl[0]});
    @(negedge clk);
    chk("R9 transmit-only row", {16'd0, pin_rx_o}, {16'd0, m_tbl[2]});
    tx_run = 1'b0; rx_run = 1'b1;
    @(negedge clk);
    chk("R9 receive-only row", {16'd0, pin_rx_o}, {16'd0, m_tbl[4]});
    tx_run = 1'b1;
    @(negedge clk);
    chk("R9 duplex row", {16'd0, pin_rx_o}, {16'd0, m_tbl[6]});

    // Random mix of sources and radio conditions (R6 R7 R9 R10)
    for (int it = 0; it < 300; it++) begin
      if ((it % 10) == 0) begin
        for (int a = 4; a < 16; a += 2) wr(5'(a), 16'($urandom));
        wr(5'd0, 16'($urandom)); wr(5'd2, 16'($urandom));
        wr(5'(16 + 2*($urandom % 8)), 16'($urandom));
      end
      @(negedge clk);
      tx_run = 1'($urandom); rx_run = 1'($urandom);
      dbg0_rx = 16'($urandom); dbg1_rx = 16'($urandom);
      dbg0_tx = 16'($urandom); dbg1_tx = 16'($urandom);
      pin_rx_i = 16'($urandom); pin_tx_i = 16'($urandom);
      row = state_row(tx_run, rx_run);
      @(negedge clk);
      check_pins("R6 R7 R9 mixed sources", row);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule